// File: doc/BRIEF.md
# Single-Carrier Five-Level Inverter Modulator

This block turns a signed digital sine reference into the eight gate drives of a five-level single-phase inverter. The inverter is built from an H-bridge whose input is fed by four extra switches sitting on a split DC link. Only one unipolar triangular carrier, peaking at the carrier amplitude input, is used for every band. The block folds the reference onto that carrier instead of stacking several carriers. It takes the magnitude of the reference. Below the amplitude it compares that magnitude with the carrier. Above the amplitude it subtracts the amplitude first. The sign of the reference picks the H-bridge polarity.

The four link switches are toggled at carrier rate to form zero, half and full magnitude. For the half magnitude either the positive-side or the negative-side link switch conducts, and the block alternates between them on every entry into a half state so that the two link capacitors share the charge evenly. The H-bridge legs change only at the fundamental zero crossing. Every level change is broken into single steps, and each complementary switch pair gets a programmable dead time in which both of its switches are off.

Top module: `five_level_pwm`

## Requirements
- R1: While reset is low the level code is 0, the positive link upper switch and the negative link lower switch are off, their complements are on, the bridge is in positive polarity (leg A high and leg B low switches on), and the other bridge switches are off.
- R2: When the reference magnitude is at most the carrier amplitude, the target magnitude is 1 if the magnitude is strictly greater than the carrier, and 0 otherwise. Equality gives 0.
- R3: When the reference magnitude is strictly greater than the carrier amplitude, the target magnitude is 2 if (magnitude minus amplitude) is strictly greater than the carrier, and 1 otherwise.
- R4: A negative reference uses its magnitude in R2 and R3, and the target level takes a negative sign.
- R5: The registered level moves by at most one step per clock toward the target level.
- R6: Each time the level enters magnitude 1 from another magnitude, the conducting half-level link switch alternates. The first entry after reset uses the positive link upper switch, and the next entry uses the negative link lower switch.
- R7: At magnitude 2 both the positive link upper switch and the negative link lower switch are on. At magnitude 0 both are off. Within each pair the complement switch takes the opposite state once settled, and the two switches of a pair are never on together.
- R8: The bridge polarity is positive (leg A high, leg B low) or negative (leg A low, leg B high). It changes only on a clock in which the registered level is 0, and takes the sign of the reference.
- R9: When a pair's requested state changes with a dead-time setting D greater than 0, both switches of the pair are off for exactly D clocks, and then the new switch turns on. With D equal to 0 the pair swaps in one clock.
- R10: The level code is a 3-bit two's complement value from -2 to +2, registered on each clock. The gate outputs follow the registered level one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 12 | Signed reference sample |
| carrierIn | input | 12 | Unsigned triangular carrier value |
| carrierAmp | input | 12 | Carrier peak value |
| deadTime | input | 8 | Dead time in clocks |
| gPosUp | output | 1 | Positive link upper switch |
| gPosDn | output | 1 | Positive link complement switch |
| gNegDn | output | 1 | Negative link lower switch |
| gNegUp | output | 1 | Negative link complement switch |
| gAHi | output | 1 | Bridge leg A high switch |
| gALo | output | 1 | Bridge leg A low switch |
| gBHi | output | 1 | Bridge leg B high switch |
| gBLo | output | 1 | Bridge leg B low switch |
| levelCode | output | 3 | Signed output level, -2 to +2 |

## Verification
The bench targets the strict comparisons at the band edges. A reference equal to the amplitude must stay in the lower band, and a carrier equal to the magnitude must give the lower result; an off-by-one compare changes the level code there. It counts half-level entries across lower-band, upper-band and negative excursions, so a selector that toggles on every half-level clock, or does not toggle on an exit from full level, lights the wrong link switch. A swing from -2 to +2 is checked cycle by cycle for single steps, for the one-clock gate lag and for the bridge flipping only after level 0. A dead time of three clocks exposes a counter that is one clock short or long, or a pair that turns on the new switch before the old one is off.

// File: rtl/fivelvl_pkg.sv
package fivelvl_pkg;
  // Target produced by the band comparator
  typedef struct packed {
    logic       neg;
    logic [1:0] mag;
  } target_t;

  // Strobes from control to the gate datapath
  typedef struct packed {
    logic dcPos;   // positive link upper switch wanted
    logic dcNeg;   // negative link lower switch wanted
    logic legA;    // positive bridge polarity wanted
  } gateReq_t;
endpackage

// File: rtl/pwm_compare.sv
module pwm_compare
  import fivelvl_pkg::*;
#(
  parameter int W = 12
) (
  input  logic signed [W-1:0] refIn,
  input  logic [W-1:0]        carrierIn,
  input  logic [W-1:0]        carrierAmp,
  output target_t             tgt
);
  logic signed [W:0] refExt;
  logic [W:0] magU, ampExt, carExt, excess;
  logic upperBand;

  always_comb begin
    refExt    = {refIn[W-1], refIn};
    magU      = refExt[W] ? unsigned'(-refExt) : unsigned'(refExt);
    ampExt    = {1'b0, carrierAmp};
    carExt    = {1'b0, carrierIn};
    upperBand = magU > ampExt;
    excess    = magU - ampExt;
    tgt.neg   = refExt[W];
    if (upperBand) tgt.mag = (excess > carExt) ? 2'd2 : 2'd1;
    else           tgt.mag = (magU > carExt) ? 2'd1 : 2'd0;
  end
endmodule

// File: rtl/pwm_control.sv
module pwm_control
  import fivelvl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  target_t           tgt,
  output logic signed [2:0] levelQ,
  output gateReq_t          req
);
  logic signed [2:0] tgtLvl, levelNext;
  logic halfUse;   // 0: positive upper switch, 1: negative lower switch
  logic posQ;
  logic halfNow, halfNext, entry;

  always_comb begin
    tgtLvl = tgt.neg ? -$signed({1'b0, tgt.mag}) : $signed({1'b0, tgt.mag});
    if (tgtLvl > levelQ)      levelNext = levelQ + 3'sd1;
    else if (tgtLvl < levelQ) levelNext = levelQ - 3'sd1;
    else                      levelNext = levelQ;
    halfNow  = (levelQ == 3'sd1) || (levelQ == -3'sd1);
    halfNext = (levelNext == 3'sd1) || (levelNext == -3'sd1);
    entry    = halfNext && !halfNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ  <= '0;
      halfUse <= 1'b1;
      posQ    <= 1'b1;
    end else begin
      levelQ <= levelNext;
      if (entry) halfUse <= ~halfUse;
      if (levelQ == 3'sd0) posQ <= ~tgt.neg;
    end
  end

  always_comb begin
    req.legA = posQ;
    if (levelQ == 3'sd0) begin
      req.dcPos = 1'b0;
      req.dcNeg = 1'b0;
    end else if (halfNow) begin
      req.dcPos = ~halfUse;
      req.dcNeg = halfUse;
    end else begin
      req.dcPos = 1'b1;
      req.dcNeg = 1'b1;
    end
  end

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ == $past(levelQ)) || (levelQ == $past(levelQ) + 3'sd1) ||
    (levelQ == $past(levelQ) - 3'sd1));

  a_r10_level_range: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ <= 3'sd2) && (levelQ >= -3'sd2));

  a_r8_flip_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (posQ != $past(posQ)) |-> ($past(levelQ) == 3'sd0));

  a_r6_alternate: assert property (@(posedge clk) disable iff (!rstN)
    (halfNow && !$past(halfNow)) |-> (halfUse != $past(halfUse)));
endmodule

// File: rtl/dead_band_pair.sv
module dead_band_pair #(
  parameter int DW      = 8,
  parameter bit INIT_HI = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqHi,
  input  logic [DW-1:0] deadTime,
  output logic          hiQ,
  output logic          loQ
);
  logic          sideQ;
  logic [DW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sideQ <= INIT_HI;
      hiQ   <= INIT_HI;
      loQ   <= ~INIT_HI;
      cntQ  <= '0;
    end else if (reqHi != sideQ) begin
      sideQ <= reqHi;
      if (deadTime == '0) begin
        hiQ  <= reqHi;
        loQ  <= ~reqHi;
        cntQ <= '0;
      end else begin
        hiQ  <= 1'b0;
        loQ  <= 1'b0;
        cntQ <= deadTime;
      end
    end else if (cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
      if (cntQ == DW'(1)) begin
        hiQ <= sideQ;
        loQ <= ~sideQ;
      end
    end
  end

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(hiQ && loQ));

  a_r9_off_first: assert property (@(posedge clk) disable iff (!rstN)
    ((reqHi != sideQ) && (deadTime != '0)) |=> (!hiQ && !loQ));
endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import fivelvl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  gateReq_t      req,
  input  logic [DW-1:0] deadTime,
  output logic [3:0]    onSide,
  output logic [3:0]    offSide
);
  localparam int NPAIR = 4;
  localparam logic [NPAIR-1:0] INIT_MASK = 4'b0100;

  logic [NPAIR-1:0] reqVec;
  assign reqVec = {~req.legA, req.legA, req.dcNeg, req.dcPos};

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    dead_band_pair #(.DW(DW), .INIT_HI(INIT_MASK[i])) u_pair (
      .clk      (clk),
      .rstN     (rstN),
      .reqHi    (reqVec[i]),
      .deadTime (deadTime),
      .hiQ      (onSide[i]),
      .loQ      (offSide[i])
    );
  end
endmodule

// File: rtl/five_level_pwm.sv
module five_level_pwm
  import fivelvl_pkg::*;
#(
  parameter int W  = 12,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic signed [W-1:0] refIn,
  input  logic [W-1:0]        carrierIn,
  input  logic [W-1:0]        carrierAmp,
  input  logic [DW-1:0]       deadTime,
  output logic                gPosUp,
  output logic                gPosDn,
  output logic                gNegDn,
  output logic                gNegUp,
  output logic                gAHi,
  output logic                gALo,
  output logic                gBHi,
  output logic                gBLo,
  output logic signed [2:0]   levelCode
);
  target_t    tgt;
  gateReq_t   req;
  logic [3:0] onSide, offSide;

  pwm_compare #(.W(W)) u_compare (
    .refIn      (refIn),
    .carrierIn  (carrierIn),
    .carrierAmp (carrierAmp),
    .tgt        (tgt)
  );

  pwm_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .tgt    (tgt),
    .levelQ (levelCode),
    .req    (req)
  );

  gate_datapath #(.DW(DW)) u_gates (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .deadTime (deadTime),
    .onSide   (onSide),
    .offSide  (offSide)
  );

  assign gPosUp = onSide[0];
  assign gPosDn = offSide[0];
  assign gNegDn = onSide[1];
  assign gNegUp = offSide[1];
  assign gAHi   = onSide[2];
  assign gALo   = offSide[2];
  assign gBHi   = onSide[3];
  assign gBLo   = offSide[3];
endmodule

// File: tb/five_level_pwm_bench.sv
module five_level_pwm_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [11:0] refIn = '0;
  logic [11:0] carrierIn = '0;
  logic [11:0] carrierAmp = 12'd1000;
  logic [7:0]  deadTime = '0;
  logic gPosUp, gPosDn, gNegDn, gNegUp, gAHi, gALo, gBHi, gBLo;
  logic signed [2:0] levelCode;
  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  five_level_pwm u_five_level_pwm (
    .clk(clk), .rstN(rstN), .refIn(refIn), .carrierIn(carrierIn),
    .carrierAmp(carrierAmp), .deadTime(deadTime),
    .gPosUp(gPosUp), .gPosDn(gPosDn), .gNegDn(gNegDn), .gNegUp(gNegUp),
    .gAHi(gAHi), .gALo(gALo), .gBHi(gBHi), .gBLo(gBLo),
    .levelCode(levelCode)
  );

  // gate vector: {posUp, posDn, negDn, negUp, aHi, aLo, bHi, bLo}
  function automatic logic [7:0] gv();
    return {gPosUp, gPosDn, gNegDn, gNegUp, gAHi, gALo, gBHi, gBLo};
  endfunction

  task automatic chkLvl(string tag, int exp);
    compared++;
    if (int'(levelCode) != exp) begin
      mismatched++;
      $display("FAIL %s level actual=%0d expected=%0d", tag, levelCode, exp);
    end
  endtask

  task automatic chkGates(string tag, logic [7:0] exp);
    compared++;
    if (gv() !== exp) begin
      mismatched++;
      $display("FAIL %s gates actual=%b expected=%b", tag, gv(), exp);
    end
  endtask

  task automatic drive(int r, int c);
    @(negedge clk);
    refIn = 12'(r);
    carrierIn = 12'(c);
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    waitN(3);
    chkLvl("R1 reset", 0);
    chkGates("R1 reset", 8'b01011001);
    rstN = 1'b1;
  endtask

  task automatic testLowBand();
    drive(500, 300); waitN(6);
    chkLvl("R2 lower band above carrier", 1);
    chkGates("R6 first half entry positive switch", 8'b10011001);
    drive(200, 300); waitN(6);
    chkLvl("R2 lower band below carrier", 0);
    chkGates("R7 zero level both off", 8'b01011001);
    drive(500, 300); waitN(6);
    chkGates("R6 second half entry negative switch", 8'b01101001);
  endtask

  task automatic testUpperBand();
    drive(0, 300); waitN(6);
    drive(1500, 300); waitN(1);
    chkLvl("R5 first step only", 1);
    waitN(5);
    chkLvl("R3 upper band full", 2);
    chkGates("R7 full level both on", 8'b10101001);
    drive(1200, 300); waitN(6);
    chkLvl("R3 upper band half", 1);
    chkGates("R6 entry from full toggles", 8'b01101001);
  endtask

  task automatic testEdges();
    drive(1000, 999); waitN(6);
    chkLvl("R2 magnitude equal amplitude stays lower band", 1);
    chkGates("R6 no entry while held", 8'b01101001);
    drive(1000, 1000); waitN(6);
    chkLvl("R2 equal carrier gives zero", 0);
  endtask

  task automatic testNegative();
    drive(-1500, 300); waitN(6);
    chkLvl("R4 negative full", -2);
    chkGates("R8 negative polarity", 8'b10100110);
  endtask

  task automatic testSwing();
    drive(1500, 300); waitN(1);
    chkLvl("R5 step -1", -1);
    waitN(1);
    chkLvl("R5 step 0", 0);
    chkGates("R10 gates lag one clock", 8'b01100110);
    waitN(1);
    chkLvl("R5 step 1", 1);
    chkGates("R8 polarity held until zero", 8'b01010110);
    waitN(1);
    chkLvl("R5 step 2", 2);
    chkGates("R8 polarity flips after zero", 8'b10011001);
    waitN(3);
    chkGates("R7 full positive settled", 8'b10101001);
  endtask

  task automatic testDeadTime();
    @(negedge clk); deadTime = 8'd3;
    drive(500, 300); waitN(1);
    chkLvl("R9 level moves first", 1);
    chkGates("R9 gates unchanged at level edge", 8'b10101001);
    waitN(1);
    chkGates("R9 both off first dead clock", 8'b00101001);
    waitN(2);
    chkGates("R9 both off last dead clock", 8'b00101001);
    waitN(1);
    chkGates("R9 complement on after dead time", 8'b01101001);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    testReset();
    testLowBand();
    testUpperBand();
    testEdges();
    testNegative();
    testSwing();
    testDeadTime();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule